// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block carries one coprocessor instruction from issue to completion over a simple request/reply interface to an external coprocessor. It presents a phase code to the coprocessor each cycle and reads back a two-bit reply. Depending on the operation, it finishes after a single data phase (a register move in either direction, or a data operation) or walks a run of memory words (a load or a store), raising read or write strobes and stepping the address one word at a time for as long as the coprocessor asks for more.

Three cases end an instruction early. A coprocessor that is not enabled in the access mask turns the instruction into an undefined-instruction exception before any phase is sent. A busy coprocessor can be interrupted by a pending reset, fast interrupt or interrupt, which abandons the instruction with an interrupt phase. A memory abort stops a transfer. Base write-back after a transfer is optional. Whether it still happens after an abort is chosen by a parameter that selects the early or the late abort model.

Top module: `cp_handshake_seq`

## Requirements
- R1: A start seen while idle whose coprocessor bit in `cp_allow` is 0 gives `exc_undef` and `done` in the next cycle, and `cp_phase` stays idle (0), so the coprocessor is never contacted.
- R2: An accepted start shows `cp_phase` = 1 (first) in the next cycle. Each busy reply (1) with no event pending gives `cp_phase` = 2 (busy) in the following cycle.
- R3: A busy reply while an event is pending gives, in the next cycle, `cp_phase` = 3 (interrupt), the matching exception output and `done`. No data phase follows.
- R4: Event priority is reset first, then fast interrupt if `fiq_mask` is 0, then interrupt if `irq_mask` is 0. A masked line is ignored, and at most one of `exc_reset`, `exc_fiq` and `exc_irq` is high.
- R5: A "can't" reply (2) during the first or busy phase gives `exc_undef` and `done` in the next cycle, with `cp_phase` back at 0.
- R6: Any reply other than 1 or 2 during the first or busy phase opens the data phase (`cp_phase` = 4). For a load (op 3) `mem_rd` is high, for a store (op 4) `mem_wr` is high, and the first `mem_addr` equals `base_addr`. Each "more" reply (3) in a data phase without an abort moves the next word at `mem_addr` + 4.
- R7: `mem_abort` during a strobed data phase ends the transfer. In the next cycle `exc_abort` and `done` are high and both strobes are low.
- R8: With `wb_req` set, a transfer that ends normally pulses `base_wb` together with `done`, and `base_wb_addr` is the last word address + 4. After an abort, write-back is suppressed when `EARLY_ABORT` = 1 and still performed (same value) when `EARLY_ABORT` = 0.
- R9: A register move (op 0 or 1) or a data operation (op 2) has exactly one data phase, with no memory strobes, whatever the reply in it. `done` follows in the next cycle.
- R10: After reset every output is 0. `done` is a one-cycle pulse per instruction, and a start seen while an instruction is in progress is ignored.
- R11: Operation codes are 0 move to coprocessor, 1 move from coprocessor, 2 data operation, 3 load, 4 store. Codes 5 to 7 are treated as undefined, the same way as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue an instruction (sampled while idle) |
| op_code | input | 3 | Operation code (R11) |
| cp_sel | input | CP_NUM_W | Coprocessor number |
| cp_allow | input | 2**CP_NUM_W | Access-allowed mask, one bit per coprocessor |
| wb_req | input | 1 | Base write-back requested |
| base_addr | input | ADDR_W | First word address of a transfer |
| cp_reply | input | 2 | 0 accept, 1 busy, 2 can't, 3 more |
| mem_abort | input | 1 | Memory abort for the current strobed word |
| rst_pend | input | 1 | Reset pending |
| fiq_pend | input | 1 | Fast interrupt pending |
| fiq_mask | input | 1 | Fast interrupt masked |
| irq_pend | input | 1 | Interrupt pending |
| irq_mask | input | 1 | Interrupt masked |
| cp_phase | output | 3 | 0 idle, 1 first, 2 busy, 3 interrupt, 4 data |
| mem_addr | output | ADDR_W | Word address, valid with a strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| base_wb | output | 1 | Base write-back pulse |
| base_wb_addr | output | ADDR_W | Updated base value |
| exc_undef | output | 1 | Undefined-instruction exception pulse |
| exc_abort | output | 1 | Abort exception pulse |
| exc_fiq | output | 1 | Fast interrupt taken pulse |
| exc_irq | output | 1 | Interrupt taken pulse |
| exc_reset | output | 1 | Reset taken pulse |
| done | output | 1 | Instruction completed or abandoned |

## Verification
The bench builds two copies side by side with ADDR_W = 32 and CP_NUM_W = 4, one with EARLY_ABORT = 1 and one with EARLY_ABORT = 0. Both get the same stimulus, so a single aborted store with write-back requested exercises both abort models in one run. With 16 coprocessor numbers, masks can enable a selected number, disable it, or leave a neighbouring one enabled. The address width leaves room for multi-word walks without wrap-around.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FIRST = 3'd1,
      PH_BUSY  = 3'd2,
      PH_INTR  = 3'd3,
      PH_DATA  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      RP_ACCEPT = 2'd0,
      RP_BUSY   = 2'd1,
      RP_CANT   = 2'd2,
      RP_MORE   = 2'd3
   } reply_e;

   typedef enum logic [2:0] {
      OP_MOVE_TO   = 3'd0,
      OP_MOVE_FROM = 3'd1,
      OP_DATAPROC  = 3'd2,
      OP_LOAD      = 3'd3,
      OP_STORE     = 3'd4
   } op_e;

   // event slots, index 0 has the highest priority
   localparam int EV_COUNT = 3;
   localparam int EV_RESET = 0;
   localparam int EV_FIQ   = 1;
   localparam int EV_IRQ   = 2;

   function automatic logic op_is_mem(input logic [2:0] op);
      return (op == OP_LOAD) || (op == OP_STORE);
   endfunction

   function automatic logic op_is_load(input logic [2:0] op);
      return op == OP_LOAD;
   endfunction

   function automatic logic op_is_legal(input logic [2:0] op);
      return op <= OP_STORE;
   endfunction

endpackage

// File: rtl/cphs_gate.sv
module cphs_gate #(
   parameter int CP_NUM_W = 4
) (
   input  logic [CP_NUM_W-1:0]      cp_sel,
   input  logic [(1<<CP_NUM_W)-1:0] cp_allow,
   input  logic [2:0]               op_code,
   output logic                     grant
);
   import cphs_pkg::*;

   localparam int NUM_CP = 1 << CP_NUM_W;

   logic [NUM_CP-1:0] sel_hot;

   // one-hot decode of the coprocessor number, one slot per coprocessor
   for (genvar g = 0; g < NUM_CP; g++) begin : g_sel
      assign sel_hot[g] = (cp_sel == CP_NUM_W'(g));
   end

   assign grant = |(sel_hot & cp_allow) && op_is_legal(op_code);

endmodule

// File: rtl/cphs_event_arb.sv
module cphs_event_arb #(
   parameter int N = 3
) (
   input  logic [N-1:0] raw,
   input  logic [N-1:0] mask,
   output logic [N-1:0] pick,
   output logic         any
);
   logic [N-1:0] live;
   logic [N:0]   blocked;

   assign live       = raw & ~mask;
   assign blocked[0] = 1'b0;

   // fixed priority chain, lower index wins
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign pick[g]      = live[g] & ~blocked[g];
      assign blocked[g+1] = blocked[g] | live[g];
   end

   assign any = blocked[N];

   always_comb begin
      assert_top_wins_R4: assert (!(live[0]) || pick[0]);
   end

endmodule

// File: rtl/cphs_addr_walk.sv
module cphs_addr_walk #(
   parameter int ADDR_W      = 32,
   parameter int WORD_BYTES  = 4,
   parameter bit EARLY_ABORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] next_addr,
   output logic              wb_on_abort
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= base;
      else if (step) addr <= next_addr;
   end

   assign next_addr = addr + STEP;

   // abort model picks whether the base survives an abort
   if (EARLY_ABORT) begin : g_early
      assign wb_on_abort = 1'b0;
   end else begin : g_late
      assign wb_on_abort = 1'b1;
   end

   assert_step_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr == $past(addr) + STEP));

endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq #(
   parameter int ADDR_W      = 32,
   parameter int CP_NUM_W    = 4,
   parameter int WORD_BYTES  = 4,
   parameter bit EARLY_ABORT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [2:0]               op_code,
   input  logic [CP_NUM_W-1:0]      cp_sel,
   input  logic [(1<<CP_NUM_W)-1:0] cp_allow,
   input  logic                     wb_req,
   input  logic [ADDR_W-1:0]        base_addr,
   input  logic [1:0]               cp_reply,
   input  logic                     mem_abort,
   input  logic                     rst_pend,
   input  logic                     fiq_pend,
   input  logic                     fiq_mask,
   input  logic                     irq_pend,
   input  logic                     irq_mask,
   output logic [2:0]               cp_phase,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic                     base_wb,
   output logic [ADDR_W-1:0]        base_wb_addr,
   output logic                     exc_undef,
   output logic                     exc_abort,
   output logic                     exc_fiq,
   output logic                     exc_irq,
   output logic                     exc_reset,
   output logic                     done
);
   import cphs_pkg::*;

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("cp_handshake_seq: ADDR_W out of range");
   end
   if (CP_NUM_W < 1 || CP_NUM_W > 6) begin : g_bad_cp_w
      $error("cp_handshake_seq: CP_NUM_W out of range");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("cp_handshake_seq: WORD_BYTES must be a power of two");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_HAND, ST_DATA} st_e;

   st_e               st_q;
   phase_e            phase_q;
   logic [2:0]        op_q;
   logic              wbreq_q;
   logic              rd_q, wr_q;
   logic              done_q, undef_q, abort_q, wb_q;
   logic [EV_COUNT-1:0] ev_q;
   logic [ADDR_W-1:0] wbaddr_q;

   logic              grant;
   logic [EV_COUNT-1:0] ev_raw, ev_mask, ev_pick;
   logic              ev_any;
   logic              walk_load, walk_step;
   logic [ADDR_W-1:0] walk_addr, walk_next;
   logic              wb_on_abort;
   reply_e            reply;
   logic              is_mem;

   assign reply  = reply_e'(cp_reply);
   assign is_mem = op_is_mem(op_q);

   cphs_gate #(.CP_NUM_W(CP_NUM_W)) u_gate (
      .cp_sel   (cp_sel),
      .cp_allow (cp_allow),
      .op_code  (op_code),
      .grant    (grant)
   );

   assign ev_raw[EV_RESET]  = rst_pend;
   assign ev_raw[EV_FIQ]    = fiq_pend;
   assign ev_raw[EV_IRQ]    = irq_pend;
   assign ev_mask[EV_RESET] = 1'b0;
   assign ev_mask[EV_FIQ]   = fiq_mask;
   assign ev_mask[EV_IRQ]   = irq_mask;

   cphs_event_arb #(.N(EV_COUNT)) u_arb (
      .raw  (ev_raw),
      .mask (ev_mask),
      .pick (ev_pick),
      .any  (ev_any)
   );

   assign walk_load = (st_q == ST_IDLE) && start && grant;
   assign walk_step = (st_q == ST_DATA) && is_mem && !mem_abort && (reply == RP_MORE);

   cphs_addr_walk #(
      .ADDR_W      (ADDR_W),
      .WORD_BYTES  (WORD_BYTES),
      .EARLY_ABORT (EARLY_ABORT)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (walk_load),
      .base        (base_addr),
      .step        (walk_step),
      .addr        (walk_addr),
      .next_addr   (walk_next),
      .wb_on_abort (wb_on_abort)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         phase_q  <= PH_IDLE;
         op_q     <= '0;
         wbreq_q  <= 1'b0;
         rd_q     <= 1'b0;
         wr_q     <= 1'b0;
         done_q   <= 1'b0;
         undef_q  <= 1'b0;
         abort_q  <= 1'b0;
         wb_q     <= 1'b0;
         ev_q     <= '0;
         wbaddr_q <= '0;
      end else begin
         done_q  <= 1'b0;
         undef_q <= 1'b0;
         abort_q <= 1'b0;
         wb_q    <= 1'b0;
         ev_q    <= '0;
         case (st_q)
            ST_IDLE: begin
               phase_q <= PH_IDLE;
               if (start) begin
                  if (grant) begin
                     st_q    <= ST_HAND;
                     phase_q <= PH_FIRST;
                     op_q    <= op_code;
                     wbreq_q <= wb_req;
                  end else begin
                     undef_q <= 1'b1;
                     done_q  <= 1'b1;
                  end
               end
            end
            ST_HAND: begin
               case (reply)
                  RP_BUSY: begin
                     if (ev_any) begin
                        phase_q <= PH_INTR;
                        ev_q    <= ev_pick;
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                     end else begin
                        phase_q <= PH_BUSY;
                     end
                  end
                  RP_CANT: begin
                     phase_q <= PH_IDLE;
                     undef_q <= 1'b1;
                     done_q  <= 1'b1;
                     st_q    <= ST_IDLE;
                  end
                  default: begin
                     phase_q <= PH_DATA;
                     st_q    <= ST_DATA;
                     rd_q    <= is_mem && op_is_load(op_q);
                     wr_q    <= is_mem && !op_is_load(op_q);
                  end
               endcase
            end
            ST_DATA: begin
               if (!is_mem) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
                  st_q    <= ST_IDLE;
               end else if (mem_abort) begin
                  phase_q  <= PH_IDLE;
                  rd_q     <= 1'b0;
                  wr_q     <= 1'b0;
                  abort_q  <= 1'b1;
                  done_q   <= 1'b1;
                  wb_q     <= wbreq_q && wb_on_abort;
                  wbaddr_q <= walk_next;
                  st_q     <= ST_IDLE;
               end else if (reply != RP_MORE) begin
                  phase_q  <= PH_IDLE;
                  rd_q     <= 1'b0;
                  wr_q     <= 1'b0;
                  done_q   <= 1'b1;
                  wb_q     <= wbreq_q;
                  wbaddr_q <= walk_next;
                  st_q     <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cp_phase     = phase_q;
   assign mem_addr     = walk_addr;
   assign mem_rd       = rd_q;
   assign mem_wr       = wr_q;
   assign base_wb      = wb_q;
   assign base_wb_addr = wbaddr_q;
   assign exc_undef    = undef_q;
   assign exc_abort    = abort_q;
   assign exc_reset    = ev_q[EV_RESET];
   assign exc_fiq      = ev_q[EV_FIQ];
   assign exc_irq      = ev_q[EV_IRQ];
   assign done         = done_q;

   // R1 / R11: refused instruction never reaches the coprocessor
   assert_refuse_no_contact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start && !grant) |=> (exc_undef && done && cp_phase == PH_IDLE));

   assert_first_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && start && grant) |=> (cp_phase == PH_FIRST));

   assert_intr_abandons_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_INTR) |-> (done && !mem_rd && !mem_wr));

   assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_reset, exc_fiq, exc_irq}));

   assert_cant_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_reply == RP_CANT)
      |=> (exc_undef && done && cp_phase == PH_IDLE));

   assert_strobe_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (cp_phase == PH_DATA && !(mem_rd && mem_wr)));

   assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && mem_abort) |=> (exc_abort && done && !mem_rd && !mem_wr));

   if (EARLY_ABORT) begin : g_chk_early
      assert_early_keeps_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
         exc_abort |-> !base_wb);
   end

   assert_single_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_DATA && !mem_rd && !mem_wr) |=> (done && cp_phase == PH_IDLE));

   assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_BUSY && cp_reply == RP_BUSY && !rst_pend
       && !(fiq_pend && !fiq_mask) && !(irq_pend && !irq_mask)) |=> (cp_phase == PH_BUSY && !done));

endmodule

// File: tb/test_cp_handshake_seq.sv
`timescale 1ns/1ps
module test_cp_handshake_seq;
   localparam int AW = 32;
   localparam int CW = 4;
   localparam int NCP = 1 << CW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [2:0]     op_code = '0;
   logic [CW-1:0]  cp_sel = '0;
   logic [NCP-1:0] cp_allow = '0;
   logic           wb_req = 1'b0;
   logic [AW-1:0]  base_addr = '0;
   logic [1:0]     cp_reply = '0;
   logic           mem_abort = 1'b0;
   logic           rst_pend = 1'b0, fiq_pend = 1'b0, fiq_mask = 1'b0;
   logic           irq_pend = 1'b0, irq_mask = 1'b0;

   logic [2:0]    ph_e, ph_l;
   logic [AW-1:0] ma_e, ma_l, wa_e, wa_l;
   logic rd_e, rd_l, wr_e, wr_l, wb_e, wb_l, un_e, un_l, ab_e, ab_l;
   logic fq_e, fq_l, iq_e, iq_l, rs_e, rs_l, dn_e, dn_l;

   cp_handshake_seq #(.ADDR_W(AW), .CP_NUM_W(CW), .EARLY_ABORT(1'b1)) i_cp_handshake_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .cp_sel(cp_sel),
      .cp_allow(cp_allow), .wb_req(wb_req), .base_addr(base_addr), .cp_reply(cp_reply),
      .mem_abort(mem_abort), .rst_pend(rst_pend), .fiq_pend(fiq_pend), .fiq_mask(fiq_mask),
      .irq_pend(irq_pend), .irq_mask(irq_mask), .cp_phase(ph_e), .mem_addr(ma_e),
      .mem_rd(rd_e), .mem_wr(wr_e), .base_wb(wb_e), .base_wb_addr(wa_e), .exc_undef(un_e),
      .exc_abort(ab_e), .exc_fiq(fq_e), .exc_irq(iq_e), .exc_reset(rs_e), .done(dn_e));

   cp_handshake_seq #(.ADDR_W(AW), .CP_NUM_W(CW), .EARLY_ABORT(1'b0)) i_cp_handshake_seq_late (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .cp_sel(cp_sel),
      .cp_allow(cp_allow), .wb_req(wb_req), .base_addr(base_addr), .cp_reply(cp_reply),
      .mem_abort(mem_abort), .rst_pend(rst_pend), .fiq_pend(fiq_pend), .fiq_mask(fiq_mask),
      .irq_pend(irq_pend), .irq_mask(irq_mask), .cp_phase(ph_l), .mem_addr(ma_l),
      .mem_rd(rd_l), .mem_wr(wr_l), .base_wb(wb_l), .base_wb_addr(wa_l), .exc_undef(un_l),
      .exc_abort(ab_l), .exc_fiq(fq_l), .exc_irq(iq_l), .exc_reset(rs_l), .done(dn_l));

   int n_checks = 0;
   int n_fail = 0;
   string tag = "R10";
   int rq[$];
   int aq[$];

   // behavioural reference model: expected outputs for the coming cycle
   int m_st = 0, m_phase = 0, m_op = 0, m_wbr = 0;
   int m_rd = 0, m_wr = 0, m_done = 0, m_undef = 0, m_abt = 0;
   int m_rst = 0, m_fiq = 0, m_irq = 0, m_wbe = 0, m_wbl = 0;
   longint m_addr = 0, m_wba = 0;

   task automatic finish_ok();
      m_done = 1; m_rd = 0; m_wr = 0; m_phase = 0; m_st = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_phase = 0; m_rd = 0; m_wr = 0; m_done = 0; m_undef = 0;
         m_abt = 0; m_rst = 0; m_fiq = 0; m_irq = 0; m_wbe = 0; m_wbl = 0;
      end else begin
         m_done = 0; m_undef = 0; m_abt = 0; m_rst = 0; m_fiq = 0; m_irq = 0;
         m_wbe = 0; m_wbl = 0;
         case (m_st)
            0: begin
               m_phase = 0;
               if (start) begin
                  if (!cp_allow[cp_sel] || op_code > 3'd4) begin
                     m_undef = 1; m_done = 1;
                  end else begin
                     m_st = 1; m_phase = 1; m_op = int'(op_code); m_wbr = int'(wb_req);
                     m_addr = longint'(base_addr);
                  end
               end
            end
            1: begin
               if (cp_reply == 2'd1) begin
                  if (rst_pend) m_rst = 1;
                  else if (fiq_pend && !fiq_mask) m_fiq = 1;
                  else if (irq_pend && !irq_mask) m_irq = 1;
                  if (m_rst + m_fiq + m_irq > 0) begin
                     m_phase = 3; m_done = 1; m_st = 0;
                  end else m_phase = 2;
               end else if (cp_reply == 2'd2) begin
                  m_undef = 1; m_done = 1; m_phase = 0; m_st = 0;
               end else begin
                  m_st = 2; m_phase = 4;
                  m_rd = (m_op == 3) ? 1 : 0;
                  m_wr = (m_op == 4) ? 1 : 0;
               end
            end
            default: begin
               if (m_op < 3) finish_ok();
               else if (mem_abort) begin
                  m_abt = 1; m_wbl = m_wbr; m_wba = m_addr + 4;
                  finish_ok();
               end else if (cp_reply == 2'd3) m_addr = m_addr + 4;
               else begin
                  m_wbe = m_wbr; m_wbl = m_wbr; m_wba = m_addr + 4;
                  finish_ok();
               end
            end
         endcase
      end
   end

   task automatic chk(input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare both copies every cycle, then play the coprocessor and memory
   always @(negedge clk) begin
      chk("cp_phase", ph_e, m_phase);       chk("cp_phase late", ph_l, m_phase);
      chk("mem_rd", rd_e, m_rd);            chk("mem_rd late", rd_l, m_rd);
      chk("mem_wr", wr_e, m_wr);            chk("mem_wr late", wr_l, m_wr);
      if (m_rd || m_wr) begin
         chk("mem_addr", ma_e, m_addr & 64'hFFFF_FFFF);
         chk("mem_addr late", ma_l, m_addr & 64'hFFFF_FFFF);
      end
      chk("exc_undef", un_e, m_undef);      chk("exc_undef late", un_l, m_undef);
      chk("exc_abort", ab_e, m_abt);        chk("exc_abort late", ab_l, m_abt);
      chk("exc_reset", rs_e, m_rst);        chk("exc_reset late", rs_l, m_rst);
      chk("exc_fiq", fq_e, m_fiq);          chk("exc_fiq late", fq_l, m_fiq);
      chk("exc_irq", iq_e, m_irq);          chk("exc_irq late", iq_l, m_irq);
      chk("done", dn_e, m_done);            chk("done late", dn_l, m_done);
      chk("base_wb early", wb_e, m_wbe);    chk("base_wb late", wb_l, m_wbl);
      if (m_wbe) chk("base_wb_addr early", wa_e, m_wba & 64'hFFFF_FFFF);
      if (m_wbl) chk("base_wb_addr late", wa_l, m_wba & 64'hFFFF_FFFF);
      if (m_phase == 1 || m_phase == 2 || m_phase == 4)
         cp_reply = (rq.size() > 0) ? 2'(rq.pop_front()) : 2'd0;
      else cp_reply = 2'd0;
      if ((m_rd || m_wr) && aq.size() > 0) mem_abort = aq.pop_front() != 0;
      else mem_abort = 1'b0;
   end

   task automatic run(input string t, input int op, input int sel, input logic [NCP-1:0] allow,
                      input bit wb, input logic [AW-1:0] base, input bit junk);
      tag = t;
      @(negedge clk);
      start = 1'b1; op_code = 3'(op); cp_sel = CW'(sel); cp_allow = allow;
      wb_req = wb; base_addr = base;
      forever begin
         @(negedge clk);
         if (m_st == 0) begin start = 1'b0; break; end
         start = junk;
         op_code = 3'd0;
      end
      @(negedge clk);
      rq.delete(); aq.delete();
   endtask

   bit ended = 1'b0;
   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog R10 actual=%0d expected<=20000", cyc);
         summary();
      end
   end

   initial begin
      tag = "R10";                         // reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: coprocessor 5 refused, neighbour 4 enabled
      run("R1", 0, 5, 16'h0010, 1'b0, 32'h0, 1'b0);
      // R11: illegal op code 6 on an enabled coprocessor
      run("R11", 6, 2, 16'hFFFF, 1'b0, 32'h0, 1'b0);
      // R9: move to coprocessor, immediate accept
      rq = '{0, 0};
      run("R9", 0, 3, 16'h0008, 1'b0, 32'h0, 1'b0);
      // R2 / R9 / R10: data op with three busy cycles, start held while active
      rq = '{1, 1, 1, 0, 0};
      run("R2", 2, 7, 16'h0080, 1'b1, 32'h0, 1'b1);
      // R9: "more" in a register move data phase is ignored
      rq = '{0, 3};
      run("R9", 1, 1, 16'h0002, 1'b0, 32'h0, 1'b0);
      // R3: busy with an unmasked interrupt pending
      irq_pend = 1'b1; rq = '{1};
      run("R3", 1, 0, 16'h0001, 1'b0, 32'h0, 1'b0);
      // R4: fast interrupt beats interrupt
      fiq_pend = 1'b1; rq = '{1};
      run("R4", 2, 0, 16'h0001, 1'b0, 32'h0, 1'b0);
      // R4: reset beats everything
      rst_pend = 1'b1; rq = '{1, 1};
      run("R4", 2, 0, 16'h0001, 1'b0, 32'h0, 1'b0);
      rst_pend = 1'b0;
      // R4: fast interrupt masked, interrupt wins
      fiq_mask = 1'b1; rq = '{1, 1};
      run("R4", 0, 0, 16'h0001, 1'b0, 32'h0, 1'b0);
      // R4: both masked, busy continues and then accepts
      irq_mask = 1'b1; rq = '{1, 1, 0, 0};
      run("R4", 0, 0, 16'h0001, 1'b0, 32'h0, 1'b0);
      fiq_pend = 1'b0; irq_pend = 1'b0; fiq_mask = 1'b0; irq_mask = 1'b0;
      // R5: can't after one busy cycle
      rq = '{1, 2};
      run("R5", 1, 9, 16'h0200, 1'b0, 32'h0, 1'b0);
      // R6 / R8: four-word load with write-back
      rq = '{0, 3, 3, 3, 0};
      run("R6", 3, 4, 16'h0010, 1'b1, 32'h0000_1000, 1'b0);
      // R8: single-word store, no write-back
      rq = '{1, 0, 0};
      run("R8", 4, 4, 16'h0010, 1'b0, 32'h0000_3000, 1'b0);
      // R7 / R8: store aborted on second word, write-back requested
      rq = '{1, 0, 3, 0}; aq = '{0, 1};
      run("R7", 4, 12, 16'h1000, 1'b1, 32'h0000_2000, 1'b0);
      // R8: load aborted on first word, write-back requested
      rq = '{0, 3}; aq = '{1};
      run("R8", 3, 12, 16'h1000, 1'b1, 32'h0000_4000, 1'b0);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule